// File: doc/BRIEF.md
# Virtual Framebuffer Address Translator

This block sits between a display engine and memory and turns a virtual framebuffer address into a physical one. Displays that are round or otherwise non-rectangular only need storage for the pixels they actually show. The virtual frame is laid out as fixed-width lines of 16-byte blocks. A per-line table records which run of blocks is visible on that line and where the line's block 0 falls in a physical buffer. Visible blocks are packed back to back into one of four buffers. A read that lands outside the visible run is answered with a programmable default word and never touches memory.

Software fills the table, the four buffer bases, the default word and a small configuration word through a write-only register port. Each translation request is answered exactly one clock later. The response carries either the physical address or a flag saying that the default word applies. Each buffer has a sticky overflow flag, and each flag has its own interrupt enable.

Top module: `vfb_xlat`

## Requirements
- R1: After reset `rspValid`, `ovfFlags` and `irq` are 0, every table line is disabled, all buffer bases are 0 and the default word is 0, so any translation reports a default hit with value 0.
- R2: A virtual address is decoded as follows: bits [3:0] are the byte in the block, bits [11:4] are the block index, bits [11+LINE_BITS:12] are the line, and the top two bits [13+LINE_BITS:12+LINE_BITS] select physical buffer 0..3.
- R3: A block is mapped when its line is enabled and first ≤ block ≤ last. In that case `rspDefault`=0 and `rspPaddr` = base[buffer] + offset + block×16 + byte, taken modulo 2^32.
- R4: An unmapped request returns `rspDefault`=1, `rspPaddr`=0 and `rspDefVal` equal to the programmed default word.
- R5: A buffer base write whose data has any of bits [3:0] set is discarded, and the base keeps its previous value.
- R6: When configuration bit 0 (narrow mode) is set, any block index of 192 or above is unmapped, whatever the line window says.
- R7: A mapped translation whose offset + block×16 + byte is at least 4 MiB sets the overflow flag of its buffer. The flag stays set until a 1 is written to its bit in the clear register. Writing 0 to a bit leaves that flag unchanged.
- R8: `rspValid` is high in exactly the cycle after a cycle in which `reqValid` is sampled high.
- R9: `irq` is high whenever any overflow flag is set and its enable bit is set. Enable bits [4:1] of the configuration word belong to buffers 0..3.
- R10: The line offset is a 23-bit two's-complement value, so a negative offset moves block 0 below the buffer base.
- R11: Register map on `regAddr`: 0 is configuration, 1 is the default word, 2..5 are the bases of buffers 0..3, and 6 is the flag clear. When bit 15 is set, bits [LINE_BITS:1] pick a table line. Bit 0 = 0 writes {last[16:9], first[8:1], enable[0]} and bit 0 = 1 writes offset[22:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 16 | Register address |
| regWdata | input | 32 | Register write data |
| reqValid | input | 1 | Translation request valid |
| reqVaddr | input | 14+LINE_BITS | Virtual address |
| rspValid | output | 1 | Response valid, one cycle after the request |
| rspDefault | output | 1 | Block is unmapped; use the default word |
| rspPaddr | output | 32 | Physical address, 0 on a default hit |
| rspDefVal | output | 32 | Default word |
| ovfFlags | output | 4 | Sticky overflow flags, one per buffer |
| irq | output | 1 | Enabled overflow interrupt |

## Verification
A corrupted table entry or buffer base shows up at the ports in the response cycle right after the first request that touches that line or buffer. It appears as a wrong physical address or as a wrong default/mapped decision. For this reason the bench sweeps every block of every line of a small table, in both line-width modes, and it rotates the buffer select so that each base is exercised. A flag that is lost or set wrongly is visible on `ovfFlags` and `irq` in the same response cycle, and it stays visible there until it is cleared.

// File: rtl/vfb_pkg.sv
package vfb_pkg;
  localparam int PA_W     = 32;
  localparam int OFF_W    = 23;
  localparam int REL_W    = OFF_W + 2;
  localparam int OVF_LOG2 = 22;
  localparam int NBUF     = 4;
  localparam int NARROW_BLOCKS = 192;

  typedef struct packed {
    logic            cfgWe;
    logic            defWe;
    logic [NBUF-1:0] baseWe;
    logic            clrWe;
    logic            lutCtlWe;
    logic            lutOffWe;
  } vfbStrb_t;
endpackage

// File: rtl/vfb_ctrl.sv
module vfb_ctrl
  import vfb_pkg::*;
#(
  parameter int LINE_BITS = 10
) (
  input  logic                 regWe,
  input  logic [15:0]          regAddr,
  input  logic [31:0]          regWdata,
  output vfbStrb_t             strb,
  output logic [LINE_BITS-1:0] lutLine
);
  logic isLut;
  logic aligned;

  assign isLut   = regAddr[15];
  assign aligned = (regWdata[3:0] == 4'h0);
  assign lutLine = regAddr[LINE_BITS:1];

  always_comb begin
    strb = '0;
    if (regWe) begin
      if (isLut) begin
        strb.lutCtlWe = ~regAddr[0];
        strb.lutOffWe = regAddr[0];
      end else begin
        strb.cfgWe = (regAddr[14:0] == 15'd0);
        strb.defWe = (regAddr[14:0] == 15'd1);
        strb.clrWe = (regAddr[14:0] == 15'd6);
        for (int b = 0; b < NBUF; b++)
          strb.baseWe[b] = aligned && (regAddr[14:0] == 15'(b + 2));
      end
    end
  end
endmodule

// File: rtl/vfb_datapath.sv
module vfb_datapath
  import vfb_pkg::*;
#(
  parameter int LINE_BITS = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  vfbStrb_t                strb,
  input  logic [LINE_BITS-1:0]    lutLine,
  input  logic [31:0]             regWdata,
  input  logic                    reqValid,
  input  logic [13+LINE_BITS:0]   reqVaddr,
  output logic                    rspValid,
  output logic                    rspDefault,
  output logic [PA_W-1:0]         rspPaddr,
  output logic [31:0]             rspDefVal,
  output logic [NBUF-1:0]         ovfFlags,
  output logic                    irq
);
  localparam int LINES = 1 << LINE_BITS;
  localparam int VA_W  = 14 + LINE_BITS;

  logic [LINES-1:0]   lutEn;
  logic [7:0]         lutFirst [LINES];
  logic [7:0]         lutLast  [LINES];
  logic [OFF_W-1:0]   lutOff   [LINES];
  logic [PA_W-1:0]    baseReg  [NBUF];
  logic [31:0]        defReg;
  logic               narrowMode;
  logic [NBUF-1:0]    irqEn;

  // configuration and default word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      defReg     <= '0;
      narrowMode <= 1'b0;
      irqEn      <= '0;
    end else begin
      if (strb.defWe) defReg <= regWdata;
      if (strb.cfgWe) begin
        narrowMode <= regWdata[0];
        irqEn      <= regWdata[NBUF:1];
      end
    end
  end

  // buffer bases
  for (genvar b = 0; b < NBUF; b++) begin : g_base
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              baseReg[b] <= '0;
      else if (strb.baseWe[b]) baseReg[b] <= regWdata;
    end
  end

  // line table: only the enable bits need a reset value
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              lutEn <= '0;
    else if (strb.lutCtlWe) lutEn[lutLine] <= regWdata[0];
  end

  always_ff @(posedge clk) begin
    if (strb.lutCtlWe) begin
      lutFirst[lutLine] <= regWdata[8:1];
      lutLast[lutLine]  <= regWdata[16:9];
    end
    if (strb.lutOffWe) lutOff[lutLine] <= regWdata[OFF_W-1:0];
  end

  // translation
  logic [1:0]           vSel;
  logic [LINE_BITS-1:0] vLine;
  logic [7:0]           vBlk;
  logic [3:0]           vByte;
  logic                 inWindow, blkAllowed, hit;
  logic [REL_W-1:0]     relAddr;
  logic [PA_W-1:0]      physAddr;
  logic                 overReach;

  assign vSel  = reqVaddr[VA_W-1 -: 2];
  assign vLine = reqVaddr[11+LINE_BITS:12];
  assign vBlk  = reqVaddr[11:4];
  assign vByte = reqVaddr[3:0];

  assign inWindow   = (vBlk >= lutFirst[vLine]) && (vBlk <= lutLast[vLine]);
  assign blkAllowed = !narrowMode || (vBlk < 8'(NARROW_BLOCKS));
  assign hit        = lutEn[vLine] && inWindow && blkAllowed;

  assign relAddr   = {{(REL_W-OFF_W){lutOff[vLine][OFF_W-1]}}, lutOff[vLine]}
                   + REL_W'({vBlk, vByte});
  assign physAddr  = baseReg[vSel] + {{(PA_W-REL_W){relAddr[REL_W-1]}}, relAddr};
  assign overReach = !relAddr[REL_W-1] && (|relAddr[REL_W-2:OVF_LOG2]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspDefault <= 1'b0;
      rspPaddr   <= '0;
      rspDefVal  <= '0;
    end else begin
      rspValid <= reqValid;
      if (reqValid) begin
        rspDefault <= !hit;
        rspPaddr   <= hit ? physAddr : '0;
        rspDefVal  <= defReg;
      end
    end
  end

  // sticky overflow flags, write-one-to-clear
  logic [NBUF-1:0] ovfSet;
  logic [NBUF-1:0] ovfClr;
  for (genvar b = 0; b < NBUF; b++) begin : g_ovf
    assign ovfSet[b] = reqValid && hit && overReach && (vSel == 2'(b));
    assign ovfClr[b] = strb.clrWe && regWdata[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlags <= '0;
    else       ovfFlags <= (ovfFlags & ~ovfClr) | ovfSet;
  end

  assign irq = |(ovfFlags & irqEn);

  // checks
  assert_rsp_follows_req_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_no_spurious_rsp_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrWe |=> ((ovfFlags & $past(ovfFlags)) == $past(ovfFlags)));
  assert_default_zero_addr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspDefault) |-> (rspPaddr == '0));
  assert_base_aligned_R5: assert property (@(posedge clk) disable iff (!rstN)
    (baseReg[0][3:0] | baseReg[1][3:0] | baseReg[2][3:0] | baseReg[3][3:0]) == 4'h0);
endmodule

// File: rtl/vfb_xlat.sv
module vfb_xlat
  import vfb_pkg::*;
#(
  parameter int LINE_BITS = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [15:0]           regAddr,
  input  logic [31:0]           regWdata,
  input  logic                  reqValid,
  input  logic [13+LINE_BITS:0] reqVaddr,
  output logic                  rspValid,
  output logic                  rspDefault,
  output logic [31:0]           rspPaddr,
  output logic [31:0]           rspDefVal,
  output logic [3:0]            ovfFlags,
  output logic                  irq
);
  vfbStrb_t             strb;
  logic [LINE_BITS-1:0] lutLine;

  vfb_ctrl #(.LINE_BITS(LINE_BITS)) u_ctrl (
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strb     (strb),
    .lutLine  (lutLine)
  );

  vfb_datapath #(.LINE_BITS(LINE_BITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .lutLine    (lutLine),
    .regWdata   (regWdata),
    .reqValid   (reqValid),
    .reqVaddr   (reqVaddr),
    .rspValid   (rspValid),
    .rspDefault (rspDefault),
    .rspPaddr   (rspPaddr),
    .rspDefVal  (rspDefVal),
    .ovfFlags   (ovfFlags),
    .irq        (irq)
  );
endmodule

// File: tb/vfb_xlat_tb.sv
module vfb_xlat_tb;
  localparam int LB    = 3;
  localparam int LINES = 1 << LB;
  localparam int VA_W  = 14 + LB;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            regWe = 1'b0;
  logic [15:0]     regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic            reqValid = 1'b0;
  logic [VA_W-1:0] reqVaddr = '0;
  logic            rspValid, rspDefault, irq;
  logic [31:0]     rspPaddr, rspDefVal;
  logic [3:0]      ovfFlags;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench-side copy of what was programmed
  bit          mEn    [LINES];
  int          mFirst [LINES];
  int          mLast  [LINES];
  int          mOff   [LINES];
  logic [31:0] mBase  [4];
  logic [31:0] mDef;
  bit          mNarrow;

  always #2 clk = ~clk;

  vfb_xlat #(.LINE_BITS(LB)) u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .reqValid(reqValid), .reqVaddr(reqVaddr), .rspValid(rspValid),
    .rspDefault(rspDefault), .rspPaddr(rspPaddr), .rspDefVal(rspDefVal),
    .ovfFlags(ovfFlags), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic setLine(input int ln, input bit en, input int f, input int l, input int off);
    wr(16'h8000 | 16'(ln << 1), {15'd0, 8'(l), 8'(f), en});
    wr(16'h8000 | 16'(ln << 1) | 16'd1, 32'(off) & 32'h7F_FFFF);
    mEn[ln] = en; mFirst[ln] = f; mLast[ln] = l; mOff[ln] = off;
  endtask

  task automatic xlate(input int sel, input int ln, input int blk, input int byt);
    @(negedge clk);
    reqValid = 1'b1;
    reqVaddr = {2'(sel), LB'(ln), 8'(blk), 4'(byt)};
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectXlate(input string req, input int sel, input int ln, input int blk, input int byt);
    bit          m;
    logic [31:0] pa;
    xlate(sel, ln, blk, byt);
    m = mEn[ln] && blk >= mFirst[ln] && blk <= mLast[ln] && !(mNarrow && blk >= 192);
    pa = mBase[sel] + 32'(mOff[ln] + blk * 16 + byt);
    chk({req, " R8 valid"}, 64'(rspValid), 64'(1));
    chk({req, " default"}, 64'(rspDefault), 64'(!m));
    chk({req, " paddr"}, 64'(rspPaddr), m ? 64'(pa) : 64'(0));
    if (!m) chk({req, " R4 defval"}, 64'(rspDefVal), 64'(mDef));
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      mEn[i] = 0; mFirst[i] = 0; mLast[i] = 0; mOff[i] = 0;
    end
    for (int b = 0; b < 4; b++) mBase[b] = '0;
    mDef = '0; mNarrow = 0;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rspValid", 64'(rspValid), 64'(0));
    chk("R1 flags", 64'(ovfFlags), 64'(0));
    chk("R1 irq", 64'(irq), 64'(0));
    rstN = 1'b1;
    expectXlate("R1 R4 after reset", 2, 5, 17, 3);
    @(negedge clk);
    chk("R8 idle", 64'(rspValid), 64'(0));

    // R11 register programming
    wr(16'd1, 32'hDEAD_BEEF); mDef = 32'hDEAD_BEEF;
    wr(16'd2, 32'h1000_0000); mBase[0] = 32'h1000_0000;
    wr(16'd3, 32'h2000_0010); mBase[1] = 32'h2000_0010;
    wr(16'd4, 32'h3000_0100); mBase[2] = 32'h3000_0100;
    wr(16'd5, 32'h4000_0000); mBase[3] = 32'h4000_0000;
    // R5 misaligned base write is dropped: model keeps old value
    wr(16'd3, 32'h2222_2225);
    expectXlate("R5 misaligned base", 1, 0, 0, 0);

    // R10 negative offsets for lines 1..7: used = 10*i, first = 20*i
    for (int i = 0; i < LINES; i++) begin
      int f = i * 20;
      int l = (f + 100 > 255) ? 255 : f + 100;
      setLine(i, i != 5, f, l, (i * 10 - f) * 16);
    end

    // R2 R3 R4 R10 full sweep, wide mode
    for (int ln = 0; ln < LINES; ln++)
      for (int blk = 0; blk < 256; blk++)
        expectXlate("R2 R3 R10 sweep", (ln ^ blk) & 3, ln, blk, blk % 16);

    // R6 narrow mode
    setLine(0, 1, 150, 255, 0);
    wr(16'd0, 32'h1); mNarrow = 1;
    for (int ln = 0; ln < LINES; ln++)
      for (int blk = 140; blk < 256; blk++)
        expectXlate("R6 narrow", blk & 3, ln, blk, 15 - blk % 16);
    chk("R7 no flags after sweeps", 64'(ovfFlags), 64'(0));
    wr(16'd0, 32'h0); mNarrow = 0;

    // R7 R9 overflow detection, irq enable only for buffer 2
    wr(16'd0, 32'h0000_0008);
    setLine(7, 1, 0, 255, 32'h3F_FFFF);
    expectXlate("R7 just below 4MiB", 1, 7, 0, 0);
    chk("R7 below limit no flag", 64'(ovfFlags), 64'(0));
    expectXlate("R7 at 4MiB", 1, 7, 0, 1);
    chk("R7 flag set", 64'(ovfFlags), 64'(4'b0010));
    chk("R9 masked irq", 64'(irq), 64'(0));
    wr(16'd0, 32'h0000_0004);
    chk("R9 irq enabled", 64'(irq), 64'(1));
    wr(16'd6, 32'h1);
    chk("R7 clear other bit keeps flag", 64'(ovfFlags), 64'(4'b0010));
    repeat (3) @(negedge clk);
    chk("R7 sticky", 64'(ovfFlags), 64'(4'b0010));
    wr(16'd6, 32'h2);
    chk("R7 w1c", 64'(ovfFlags), 64'(0));
    chk("R9 irq drops", 64'(irq), 64'(0));
    // unmapped overreach does not flag
    setLine(7, 1, 10, 255, 32'h3F_FFFF);
    expectXlate("R7 unmapped", 3, 7, 0, 5);
    chk("R7 unmapped no flag", 64'(ovfFlags), 64'(0));

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule